// File: doc/BRIEF.md
# Serial Command-Frame Engine

This block is the device-side serial engine that runs while programming mode is active. A host drives a serial clock pin and a data pin; every transaction is a 20-bit frame: a 4-bit command code followed by a 16-bit operand, each field least-significant bit first. The host changes the data line while the serial clock is rising and the block captures it when the clock falls. Both pins are synchronised into the system clock domain, so every serial clock level must last at least four system clock cycles.

The engine reports the command code with a one-cycle strobe as soon as the fourth bit is captured, and the whole operand with a second one-cycle strobe when the frame ends. A parameter mask, indexed by command code, marks the read-type commands. For those, only the low operand byte is taken from the pin. The engine then samples a parallel read byte, turns the data pin around and returns that byte, least-significant bit first, over the last eight clocks of the frame. The two strobes are valid-only outputs with no ready: a serial host cannot be paused, so the consumer must take each strobe in the cycle it appears. The read byte is sampled once, at a fixed point in the frame, and nothing is held back waiting for it.

Top module: `sce_serial_engine`

## Requirements
- R1: A data bit is taken from the value on `sdat_in` at the falling edge of `sclk_pin`. Changes to `sdat_in` while the serial clock is low have no effect on the captured frame.
- R2: The first four captured bits form `cmd_code`, with bit 0 first. `cmd_valid` is high for exactly one cycle, in the cycle after the third rising `clk` edge that follows the fourth falling serial clock edge. `cmd_code` and `cmd_is_read` are valid in that cycle.
- R3: The next sixteen bits form `frame_operand`, with bit 0 first. `frame_done` is high for exactly one cycle, with the same latency after the twentieth falling edge, and `frame_operand` and `cmd_code` are valid in that cycle. One `frame_done` pulse occurs per completed frame.
- R4: A command whose bit in `RD_MASK` (bit index = command code) is 0 takes all sixteen operand bits from the pin, and `sdat_oe` stays 0 for the whole frame.
- R5: A command whose `RD_MASK` bit is 1 sets `cmd_is_read`. Only operand bits 7..0 are taken from the pin, and `frame_operand[15:8]` reads 0. `sdat_oe` rises after the twelfth falling edge, before the thirteenth rising edge.
- R6: `rd_byte` is sampled in the same cycle that `sdat_oe` rises. On each later rising serial clock edge, `sdat_out` presents the next bit of that byte, bit 0 first, within three `clk` cycles. Changes to `rd_byte` after sampling have no effect.
- R7: `sdat_oe` returns to 0 in the same cycle that `frame_done` is asserted.
- R8: While `prog_mode` is 0, the bit count restarts at 0 and `sdat_oe`, `sdat_out`, `cmd_valid` and `frame_done` are 0 from the next cycle on. A partial frame is dropped.
- R9: After reset, `cmd_valid`, `frame_done`, `sdat_oe`, `sdat_out`, `cmd_code`, `cmd_is_read` and `frame_operand` are all 0.
- R10: `sdat_out` is 0 whenever `sdat_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | High while programming mode is active (synchronous to clk) |
| sclk_pin | input | 1 | Serial clock from the host |
| sdat_in | input | 1 | Data pin input path |
| sdat_out | output | 1 | Data pin output value |
| sdat_oe | output | 1 | Data pin output enable |
| rd_byte | input | 8 | Byte returned for read-type commands |
| cmd_valid | output | 1 | One-cycle strobe: command code received |
| cmd_code | output | 4 | Received command code |
| cmd_is_read | output | 1 | Current command is read-type |
| frame_done | output | 1 | One-cycle strobe: frame complete |
| frame_operand | output | 16 | Received operand |

## Verification
Each serial edge on the pins passes through a two-stage synchroniser and an edge register. The strobes, `sdat_oe` and each new `sdat_out` bit therefore change at the third rising `clk` edge after the pin moves. The bench drives the pins at falling `clk` edges. It checks that each strobe is still low two falling edges after the serial clock falls, is high at the third, and is low again at the fourth. Returned bits and the output enable are sampled at the end of each serial clock phase, which lasts at least four cycles. The disturbing values placed on `sdat_in` and `rd_byte` are applied only after their capture point has passed.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int unsigned CMD_W   = 4;
  localparam int unsigned OPND_W  = 16;
  localparam int unsigned RD_W    = 8;
  localparam int unsigned SYNC_N  = 2;
  localparam int unsigned CODES   = 1 << CMD_W;
  typedef logic [CMD_W-1:0]  cmd_t;
  typedef logic [OPND_W-1:0] opnd_t;
endpackage

// File: rtl/sce_pin_sync.sv
module sce_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic sdat_pin,
  output logic sdat_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] ck_sh, dt_sh;
  logic              ck_prev;
  logic              sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sh   <= '0;
      dt_sh   <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_sh   <= {ck_sh[STAGES-2:0], sclk_pin};
      dt_sh   <= {dt_sh[STAGES-2:0], sdat_pin};
      ck_prev <= sclk_s;
    end
  end

  assign sclk_s = ck_sh[STAGES-1];
  assign sdat_s = dt_sh[STAGES-1];
  assign rise   = sclk_s & ~ck_prev;
  assign fall   = ~sclk_s & ck_prev;
endmodule

// File: rtl/sce_framer.sv
module sce_framer #(
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned OPND_W = 16,
  parameter int unsigned RD_W   = 8,
  parameter logic [(1<<CMD_W)-1:0] RD_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              fall,
  input  logic              bit_in,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              cmd_is_read,
  output logic              frame_done,
  output logic [OPND_W-1:0] operand,
  output logic              load_now,
  output logic              end_now
);
  localparam int unsigned FRAME_LEN = CMD_W + OPND_W;
  localparam int unsigned IN_RD     = OPND_W - RD_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LOAD_IDX = CNT_W'(CMD_W + IN_RD - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd_r, cmd_nxt;
  logic [OPND_W-1:0] opnd_r, opnd_nxt;
  logic              rd_flag, cv_q, fd_q;

  always_comb begin
    cmd_nxt  = (cnt == '0) ? '0 : cmd_r;
    opnd_nxt = (cnt == '0) ? '0 : opnd_r;
    for (int i = 0; i < CMD_W; i++)
      if (cnt == CNT_W'(i)) cmd_nxt[i] = bit_in;
    for (int j = 0; j < OPND_W; j++)
      if (cnt == CNT_W'(CMD_W + j) && (!rd_flag || j < IN_RD)) opnd_nxt[j] = bit_in;
  end

  assign load_now = run && fall && rd_flag && (cnt == LOAD_IDX);
  assign end_now  = run && fall && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; cmd_r <= '0; opnd_r <= '0;
      rd_flag <= 1'b0; cv_q <= 1'b0; fd_q <= 1'b0;
    end else if (!run) begin
      cnt <= '0; rd_flag <= 1'b0; cv_q <= 1'b0; fd_q <= 1'b0;
    end else begin
      cv_q <= 1'b0;
      fd_q <= 1'b0;
      if (fall) begin
        cmd_r  <= cmd_nxt;
        opnd_r <= opnd_nxt;
        cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == CMD_LAST) begin
          cv_q    <= 1'b1;
          rd_flag <= RD_MASK[cmd_nxt];
        end
        if (cnt == LAST) fd_q <= 1'b1;
      end
    end
  end

  assign cmd_valid   = cv_q;
  assign frame_done  = fd_q;
  assign cmd_code    = cmd_r;
  assign cmd_is_read = rd_flag;
  assign operand     = opnd_r;
endmodule

// File: rtl/sce_readout.sv
module sce_readout #(
  parameter int unsigned RD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            rise,
  input  logic            load,
  input  logic            finish,
  input  logic [RD_W-1:0] rd_byte,
  output logic            out_bit,
  output logic            out_en
);
  logic [RD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; out_bit <= 1'b0; out_en <= 1'b0;
    end else if (!run || finish) begin
      out_bit <= 1'b0; out_en <= 1'b0;
    end else if (load) begin
      sh     <= rd_byte;
      out_en <= 1'b1;
    end else if (rise && out_en) begin
      out_bit <= sh[0];
      sh      <= sh >> 1;
    end
  end
endmodule

// File: rtl/sce_serial_engine.sv
module sce_serial_engine
  import sce_pkg::*;
#(
  parameter logic [CODES-1:0] RD_MASK = 16'h0106
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              sclk_pin,
  input  logic              sdat_in,
  output logic              sdat_out,
  output logic              sdat_oe,
  input  logic [RD_W-1:0]   rd_byte,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              cmd_is_read,
  output logic              frame_done,
  output logic [OPND_W-1:0] frame_operand
);
  logic sdat_s, rise, fall, load_now, end_now;

  sce_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .sdat_pin(sdat_in),
    .sdat_s(sdat_s), .rise(rise), .fall(fall)
  );

  sce_framer #(.CMD_W(CMD_W), .OPND_W(OPND_W), .RD_W(RD_W), .RD_MASK(RD_MASK)) u_frm (
    .clk(clk), .rst_n(rst_n), .run(prog_mode), .fall(fall), .bit_in(sdat_s),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_is_read(cmd_is_read),
    .frame_done(frame_done), .operand(frame_operand),
    .load_now(load_now), .end_now(end_now)
  );

  sce_readout #(.RD_W(RD_W)) u_rdo (
    .clk(clk), .rst_n(rst_n), .run(prog_mode), .rise(rise),
    .load(load_now), .finish(end_now), .rd_byte(rd_byte),
    .out_bit(sdat_out), .out_en(sdat_oe)
  );
endmodule

// File: rtl/sce_serial_engine_chk.sv
module sce_serial_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_mode,
  input logic sdat_out,
  input logic sdat_oe,
  input logic cmd_valid,
  input logic cmd_is_read,
  input logic frame_done
);
  assert_quiet_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sdat_oe |-> !sdat_out);
  assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !sdat_oe);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> (!sdat_oe && !cmd_valid && !frame_done));
  assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_is_read |-> !sdat_oe);
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> cmd_is_read);
endmodule

bind sce_serial_engine sce_serial_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sdat_out(sdat_out),
  .sdat_oe(sdat_oe), .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read),
  .frame_done(frame_done)
);

// File: tb/sim_sce_serial_engine.sv
`timescale 1ns/1ps
module sim_sce_serial_engine;
  localparam logic [15:0] MASK = 16'h0106;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0, prog_mode = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic [7:0]  rdb = 8'h00;
  logic        sdat_out, sdat_oe, cmd_valid, cmd_is_read, frame_done;
  logic [3:0]  cmd_code;
  logic [15:0] frame_operand;
  int n_cmp = 0, n_bad = 0, n_done = 0, exp_done = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sce_serial_engine #(.RD_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sclk_pin(sclk),
    .sdat_in(sdat), .sdat_out(sdat_out), .sdat_oe(sdat_oe), .rd_byte(rdb),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_is_read(cmd_is_read),
    .frame_done(frame_done), .frame_operand(frame_operand)
  );

  always @(posedge clk) if (rst_n && frame_done) n_done++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [3:0] code, input logic [15:0] op,
                           input logic [7:0] rb, input int nbits);
    bit rd = MASK[code];
    logic [15:0] exp_op = rd ? {8'h00, op[7:0]} : op;
    rdb = rb;
    for (int b = 0; b < nbits; b++) begin
      logic bv = (b < 4) ? code[b] : op[b-4];
      @(negedge clk); sclk = 1'b1;
      sdat = (rd && b >= 12) ? ~bv : bv;
      repeat (H-1) @(negedge clk);
      if (b >= 12) begin
        if (rd) begin
          chk(sdat_oe === 1'b1, "R5 oe during return", sdat_oe, 1);
          chk(sdat_out === rb[b-12], "R6 returned bit", sdat_out, rb[b-12]);
        end else begin
          chk(sdat_oe === 1'b0, "R4 no drive", sdat_oe, 0);
          chk(sdat_out === 1'b0, "R10 idle out", sdat_out, 0);
        end
      end
      @(negedge clk); sclk = 1'b0;
      if (b == 3 || b == 19) begin
        @(negedge clk);
        @(negedge clk); sdat = ~bv;
        if (b == 3) chk(cmd_valid === 1'b0, "R2 strobe early", cmd_valid, 0);
        else        chk(frame_done === 1'b0, "R3 strobe early", frame_done, 0);
        @(negedge clk);
        if (b == 3) begin
          chk(cmd_valid === 1'b1, "R2 cmd strobe", cmd_valid, 1);
          chk(cmd_code === code, "R2 cmd code", cmd_code, code);
          chk(cmd_is_read === rd, "R5 read flag", cmd_is_read, rd);
        end else begin
          chk(frame_done === 1'b1, "R3 frame strobe", frame_done, 1);
          chk(frame_operand === exp_op, "R3 R1 operand", frame_operand, exp_op);
          chk(cmd_code === code, "R3 code held", cmd_code, code);
          chk(sdat_oe === 1'b0, "R7 oe released", sdat_oe, 0);
        end
        @(negedge clk);
        if (b == 3) chk(cmd_valid === 1'b0, "R2 one cycle", cmd_valid, 0);
        else        chk(frame_done === 1'b0, "R3 one cycle", frame_done, 0);
      end else begin
        @(negedge clk);
        @(negedge clk); sdat = ~bv;
        repeat (H-2) @(negedge clk);
        if (b == 11) begin
          chk(sdat_oe === rd, "R5 turnaround", sdat_oe, rd);
          rdb = ~rb;
        end
      end
    end
    if (nbits == 20) exp_done++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid === 1'b0 && frame_done === 1'b0, "R9 strobes", {cmd_valid, frame_done}, 0);
    chk(sdat_oe === 1'b0 && sdat_out === 1'b0, "R9 pin", {sdat_oe, sdat_out}, 0);
    chk(cmd_code === 4'h0 && cmd_is_read === 1'b0, "R9 code", cmd_code, 0);
    chk(frame_operand === 16'h0, "R9 operand", frame_operand, 0);
    rst_n = 1'b1;
    @(negedge clk); prog_mode = 1'b1;
    repeat (2) @(negedge clk);
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 3; p++) begin
        logic [15:0] op = (p == 0) ? (16'hA5C3 ^ (16'(c) * 16'h1111)) :
                          (p == 1) ? ~(16'h0F0F + 16'(c)) : {4'(c), 12'(c * 37 + 5)};
        logic [7:0] rb = 8'(8'h3C ^ (c * 29 + p * 71));
        run_frame(4'(c), op, rb, 20);
      end
    // R8: abort a read frame after the turnaround
    run_frame(4'h1, 16'h5AA5, 8'hC6, 14);
    @(negedge clk); prog_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdat_oe === 1'b0 && sdat_out === 1'b0, "R8 abort read", {sdat_oe, sdat_out}, 0);
    @(negedge clk); prog_mode = 1'b1;
    run_frame(4'h8, 16'h1234, 8'h9B, 20);
    // R8: abort a write frame mid-operand
    run_frame(4'h3, 16'hFFFF, 8'h00, 7);
    @(negedge clk); prog_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk(cmd_valid === 1'b0 && frame_done === 1'b0, "R8 abort strobes", {cmd_valid, frame_done}, 0);
    @(negedge clk); prog_mode = 1'b1;
    run_frame(4'h7, 16'h8001, 8'h00, 20);
    repeat (4) @(negedge clk);
    chk(n_done == exp_done, "R3 R8 frame count", n_done, exp_done);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule